// File: doc/BRIEF.md
# Dirty-Byte Log Entry Compressor

This block sits between a store path and a redo-log buffer. Each store brings in its cache-word address, the value the word held before the store and the value written. The block splits the word into equal chunks and compares the old and new copy of each one, which gives one flag bit per chunk. It then builds a compact log entry. The entry holds the address, the flag vector and only the new contents of the chunks that changed. Those chunks are packed side by side from the least significant end, and a byte count states how much of the data field is meaningful.

A store that changes nothing (a silent store) still completes its input handshake. It produces no entry, and a one-cycle acknowledge pulse is raised instead. Both edges of the block use a valid/ready handshake. The output is a single register stage controlled by a two-state machine. In `ST_EMPTY` the register holds nothing and the input is always ready. In `ST_FULL` the register holds an entry and the input is ready only when the consumer takes that entry in the same cycle.

The state machine has these transitions. It goes from EMPTY to FULL when a dirty store is accepted. It goes from FULL to FULL when the entry is taken and a dirty store is accepted in the same cycle, and also when the output stalls. It goes from FULL to EMPTY when the entry is taken and no dirty store arrives.

Top module: `dirty_log_packer`

## Requirements
- R1: Flag bit i of an entry is 1 exactly when at least one byte of chunk i differs between the old and new word. Chunk i covers bytes i*CHUNK_BYTES up to (i+1)*CHUNK_BYTES-1, and byte 0 is bits 7:0.
- R2: The new contents of the dirty chunks are placed in the data field in ascending chunk order. The lowest dirty chunk occupies bits CHUNK_BYTES*8-1:0, and each following dirty chunk takes the next chunk-sized slot above it.
- R3: The byte count of an entry equals the number of set flag bits times CHUNK_BYTES.
- R4: Every data bit at or above byte position out_bytes is zero.
- R5: A store whose old and new words are equal produces no entry. In the cycle after its handshake, out_silent is 1 for one cycle and out_valid stays 0.
- R6: A dirty store accepted at a clock edge makes out_valid 1 after that edge, and the entry carries the store's address.
- R7: in_ready is 1 when no entry is held or when out_ready is 1. While out_ready is 0, a held entry keeps its valid, address, flags and data unchanged.
- R8: With out_ready held at 1, a new store can be accepted every cycle. Each entry appears for one cycle, and out_valid returns to 0 one cycle after the last entry is taken when no further store arrives.
- R9: After reset, out_valid and out_silent are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Store offered |
| in_ready | output | 1 | Store can be accepted |
| in_addr | input | ADDR_W | Cache-word address of the store |
| in_old | input | WORD_BYTES*8 | Word value before the store |
| in_new | input | WORD_BYTES*8 | Word value written by the store |
| out_valid | output | 1 | Log entry present |
| out_ready | input | 1 | Consumer takes the entry |
| out_addr | output | ADDR_W | Address metadata of the entry |
| out_flags | output | WORD_BYTES/CHUNK_BYTES | One dirty flag per chunk |
| out_data | output | WORD_BYTES*8 | Packed dirty chunks, lowest chunk first |
| out_bytes | output | $clog2(WORD_BYTES+1) | Number of meaningful bytes in out_data |
| out_silent | output | 1 | One-cycle pulse for an accepted silent store |

## Verification
Every output of the block is registered, so an entry or a silent pulse is due one clock edge after the handshake edge. The bench drives each store on a falling edge and checks the outputs on the next falling edge. At that point the entry, its flags, its count and the silent pulse must all be visible together. While the consumer stalls, the held entry is checked again on each falling edge. After the stall releases, the replacement entry is checked one edge later, and the empty state one edge after that.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } dlp_state_e;
endpackage

// File: rtl/dlp_flag_gen.sv
module dlp_flag_gen #(
    parameter int WORD_BYTES  = 8,
    parameter int CHUNK_BYTES = 1
) (
    input  logic [WORD_BYTES*8-1:0]             old_word,
    input  logic [WORD_BYTES*8-1:0]             new_word,
    output logic [WORD_BYTES/CHUNK_BYTES-1:0]   flags
);
    localparam int CW = CHUNK_BYTES * 8;
    localparam int NC = WORD_BYTES / CHUNK_BYTES;

    for (genvar c = 0; c < NC; c++) begin : g_chunk
        assign flags[c] = (old_word[c*CW +: CW] != new_word[c*CW +: CW]);
    end
endmodule

// File: rtl/dlp_packer.sv
module dlp_packer #(
    parameter int WORD_BYTES  = 8,
    parameter int CHUNK_BYTES = 1,
    localparam int NC    = WORD_BYTES / CHUNK_BYTES,
    localparam int CNT_W = $clog2(WORD_BYTES + 1)
) (
    input  logic [NC-1:0]           flags,
    input  logic [WORD_BYTES*8-1:0] new_word,
    output logic [WORD_BYTES*8-1:0] packed_word,
    output logic [CNT_W-1:0]        byte_cnt
);
    localparam int CW = CHUNK_BYTES * 8;

    always_comb begin
        int slot;
        slot        = 0;
        packed_word = '0;
        for (int i = 0; i < NC; i++) begin
            if (flags[i]) begin
                packed_word[slot*CW +: CW] = new_word[i*CW +: CW];
                slot++;
            end
        end
        byte_cnt = CNT_W'(slot * CHUNK_BYTES);
    end
endmodule

// File: rtl/dirty_log_packer.sv
module dirty_log_packer
    import dlp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WORD_BYTES  = 8,
    parameter int CHUNK_BYTES = 1,
    localparam int DW    = WORD_BYTES * 8,
    localparam int NC    = WORD_BYTES / CHUNK_BYTES,
    localparam int CNT_W = $clog2(WORD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DW-1:0]     in_old,
    input  logic [DW-1:0]     in_new,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [NC-1:0]     out_flags,
    output logic [DW-1:0]     out_data,
    output logic [CNT_W-1:0]  out_bytes,
    output logic              out_silent
);
    dlp_state_e       state_q, state_d;
    logic [NC-1:0]    flags_w;
    logic [DW-1:0]    packed_w;
    logic [CNT_W-1:0] cnt_w;
    logic             accept, dirty;

    dlp_flag_gen #(.WORD_BYTES(WORD_BYTES), .CHUNK_BYTES(CHUNK_BYTES)) u_flags (
        .old_word (in_old),
        .new_word (in_new),
        .flags    (flags_w)
    );

    dlp_packer #(.WORD_BYTES(WORD_BYTES), .CHUNK_BYTES(CHUNK_BYTES)) u_pack (
        .flags       (flags_w),
        .new_word    (in_new),
        .packed_word (packed_w),
        .byte_cnt    (cnt_w)
    );

    assign accept = in_valid && in_ready;
    assign dirty  = |flags_w;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept && dirty) state_d = ST_FULL;
            ST_FULL:  if (out_ready)       state_d = (accept && dirty) ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Handshake outputs decoded from state
    always_comb begin
        out_valid = 1'b0;
        in_ready  = 1'b1;
        unique case (state_q)
            ST_EMPTY: begin out_valid = 1'b0; in_ready = 1'b1;      end
            ST_FULL:  begin out_valid = 1'b1; in_ready = out_ready; end
            default:  begin out_valid = 1'b0; in_ready = 1'b1;      end
        endcase
    end

    // Entry register and silent-store pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr   <= '0;
            out_flags  <= '0;
            out_data   <= '0;
            out_bytes  <= '0;
            out_silent <= 1'b0;
        end else begin
            out_silent <= accept && !dirty;
            if (accept && dirty) begin
                out_addr  <= in_addr;
                out_flags <= flags_w;
                out_data  <= packed_w;
                out_bytes <= cnt_w;
            end
        end
    end

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_old != in_new)) |=> out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_flags) && $stable(out_addr)));

    p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_bytes) == $countones(out_flags) * CHUNK_BYTES));

    p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data >> (int'(out_bytes) * 8)) == '0));

    p_silent_no_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_silent |-> !out_valid);

    p_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_flags != '0));
endmodule

// File: tb/tb_dirty_log_packer.sv
module tb_dirty_log_packer;
    logic clk = 1'b0;
    logic rst_n;
    always #10 clk = ~clk;   // 50 MHz

    logic        in_valid, out_ready;
    logic [15:0] in_addr;
    logic [31:0] in_old, in_new;

    logic        in_ready, out_valid, out_silent;
    logic [15:0] out_addr;
    logic [3:0]  out_flags;
    logic [31:0] out_data;
    logic [2:0]  out_bytes;

    logic        in_ready2, out_valid2, out_silent2;
    logic [15:0] out_addr2;
    logic [1:0]  out_flags2;
    logic [31:0] out_data2;
    logic [2:0]  out_bytes2;

    int n_tests = 0;
    int n_fail  = 0;

    dirty_log_packer #(.ADDR_W(16), .WORD_BYTES(4), .CHUNK_BYTES(1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_old(in_old), .in_new(in_new),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_flags(out_flags), .out_data(out_data), .out_bytes(out_bytes),
        .out_silent(out_silent));

    dirty_log_packer #(.ADDR_W(16), .WORD_BYTES(4), .CHUNK_BYTES(2)) dut_q2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready2),
        .in_addr(in_addr), .in_old(in_old), .in_new(in_new),
        .out_valid(out_valid2), .out_ready(out_ready), .out_addr(out_addr2),
        .out_flags(out_flags2), .out_data(out_data2), .out_bytes(out_bytes2),
        .out_silent(out_silent2));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected entry for chunk size q on a 4-byte word
    function automatic void model(input int q, input logic [31:0] o, input logic [31:0] n,
                                  output logic [3:0] fl, output logic [31:0] d, output int nb);
        logic [31:0] m;
        int slot;
        m = (32'h1 << (q*8)) - 32'h1;
        fl = '0; d = '0; slot = 0;
        for (int c = 0; c < 4/q; c++) begin
            if (((o >> (c*q*8)) & m) != ((n >> (c*q*8)) & m)) begin
                fl[c] = 1'b1;
                d = d | (((n >> (c*q*8)) & m) << (slot*q*8));
                slot++;
            end
        end
        nb = slot * q;
    endfunction

    task automatic check_entry(input logic [15:0] a, input logic [31:0] o, input logic [31:0] n);
        logic [3:0] fl; logic [31:0] d; int nb;
        model(1, o, n, fl, d, nb);
        if (fl == 4'd0) begin
            chk(out_valid == 1'b0, "R5 q1 no entry", 64'(out_valid), 64'd0);
            chk(out_silent == 1'b1, "R5 q1 silent pulse", 64'(out_silent), 64'd1);
        end else begin
            chk(out_valid == 1'b1, "R6 q1 valid", 64'(out_valid), 64'd1);
            chk(out_addr == a, "R6 q1 addr", 64'(out_addr), 64'(a));
            chk(out_flags == fl, "R1 q1 flags", 64'(out_flags), 64'(fl));
            chk(out_data == d, "R2 R4 q1 data", 64'(out_data), 64'(d));
            chk(int'(out_bytes) == nb, "R3 q1 bytes", 64'(out_bytes), 64'(nb));
            chk(out_silent == 1'b0, "R5 q1 no pulse", 64'(out_silent), 64'd0);
        end
        model(2, o, n, fl, d, nb);
        if (fl == 4'd0) begin
            chk(out_valid2 == 1'b0 && out_silent2 == 1'b1, "R5 q2 silent",
                64'({out_valid2, out_silent2}), 64'd1);
        end else begin
            chk(out_valid2 == 1'b1, "R6 q2 valid", 64'(out_valid2), 64'd1);
            chk(out_flags2 == fl[1:0], "R1 q2 flags", 64'(out_flags2), 64'(fl[1:0]));
            chk(out_data2 == d, "R2 R4 q2 data", 64'(out_data2), 64'(d));
            chk(int'(out_bytes2) == nb, "R3 q2 bytes", 64'(out_bytes2), 64'(nb));
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [31:0] o, input logic [31:0] n);
        in_valid = 1'b1; in_addr = a; in_old = o; in_new = n;
    endtask

    initial begin
        logic [31:0] o, n;
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_addr = '0; in_old = '0; in_new = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_valid2 == 1'b0, "R9 reset valid", 64'({out_valid, out_valid2}), 64'd0);
        chk(out_silent == 1'b0, "R9 reset silent", 64'(out_silent), 64'd0);
        chk(in_ready == 1'b1, "R9 reset ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Case from the requirements: zero word rewritten as 0x01020030
        drive(16'h00A0, 32'h0, 32'h01020030);
        @(negedge clk);
        in_valid = 1'b0;
        check_entry(16'h00A0, 32'h0, 32'h01020030);
        chk(out_bytes == 3'd3 && out_data == 32'h00010230, "R2 R3 example",
            64'({out_bytes, out_data}), 64'({3'd3, 32'h00010230}));

        // Sweep every byte-difference mask over several base patterns, back to back
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 16; m++) begin
                o = 32'h3C5A_96E1 * (k + 1);
                n = o;
                for (int b = 0; b < 4; b++)
                    if (m[b]) n[b*8 +: 8] = o[b*8 +: 8] ^ 8'(8'h11 * (b + 1) + k);
                drive(16'(k * 16 + m), o, n);
                @(negedge clk);
                in_valid = 1'b0;
                check_entry(16'(k * 16 + m), o, n);
                chk(in_ready == 1'b1, "R8 ready while draining", 64'(in_ready), 64'd1);
            end
        end
        @(negedge clk);
        chk(out_valid == 1'b0 && out_silent == 1'b0, "R8 drained",
            64'({out_valid, out_silent}), 64'd0);

        // Stall: entry held, input blocked, then replaced in the release cycle
        out_ready = 1'b0;
        drive(16'h0BEE, 32'h11223344, 32'h11AA3344);
        @(negedge clk);
        check_entry(16'h0BEE, 32'h11223344, 32'h11AA3344);
        drive(16'h0CAF, 32'hDEADBEEF, 32'h00ADBE00);
        for (int s = 0; s < 3; s++) begin
            chk(in_ready == 1'b0, "R7 blocked", 64'(in_ready), 64'd0);
            chk(out_valid == 1'b1 && out_data == 32'h0000_00AA && out_addr == 16'h0BEE,
                "R7 held", 64'(out_data), 64'h0000_00AA);
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R7 ready on consume", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check_entry(16'h0CAF, 32'hDEADBEEF, 32'h00ADBE00);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 empty after last", 64'(out_valid), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule